// File: doc/BRIEF.md
# Tri-Port Byte-Enabled Bus Exchanger

This block joins a CPU-side address/data port (X) to two memory-side ports: an even bank (Y) and an odd bank (Z). Each memory port has two storage registers. The write hold register is loaded from X and drives that memory port. The read hold register is loaded from that memory port and feeds X through a bank-select multiplexer. Each of the four registers has its own load enable. While its enable is high, the register follows its source, sampled on every clock. From the first clock with the enable low, it keeps its last value. That makes it a clocked form of a transparent latch.

A bank-select input (`bank_even`), a direction input (`xmit`) and a vector of active-low byte enables (`lane_oe_n`) set which port drives which byte lanes. Each bidirectional port is split into an input bus, an output bus and one output-enable bit per byte lane, so that pad drivers can sit outside the block. A decoder resolves the control inputs into one of five named transfer modes: `MODE_IDLE`, `MODE_RD_Y` (Y to X), `MODE_WR_Y` (X to Y), `MODE_RD_Z` (Z to X) and `MODE_WR_Z` (X to Z). The decode is purely combinational and holds no state, so any control pattern reaches any mode directly. `MODE_IDLE` is chosen while reset is active or when every lane enable is high. Otherwise `bank_even` and `xmit` pick one of the other four.

Top module: `tri_port_xchg`

## Requirements
- R1: While `rst_n` is low, all four hold registers are zero and every bit of `x_oe`, `y_oe` and `z_oe` is 0, whatever the control inputs are.
- R2: On a rising clock edge with `ld_xy` high, the Y write register takes `x_in`, and `y_out` shows that value from that edge on. `ld_xz` does the same for the Z write register and `z_out`.
- R3: A hold register whose load enable is low at a clock edge keeps its value, even when its source bus changes.
- R4: On a rising clock edge with `ld_yx` high, the Y read register takes `y_in`. With `ld_zx` high, the Z read register takes `z_in`.
- R5: `x_out` equals the Y read register when `bank_even` is 1 and the Z read register when `bank_even` is 0.
- R6: `x_oe[b]` is 1 exactly when `xmit` is 0 and `lane_oe_n[b]` is 0.
- R7: `y_oe[b]` is 1 exactly when `xmit`, `bank_even` are 1 and `lane_oe_n[b]` is 0. `z_oe[b]` is 1 exactly when `xmit` is 1, `bank_even` is 0 and `lane_oe_n[b]` is 0.
- R8: With every bit of `lane_oe_n` high, no output-enable bit is set on any port.
- R9: Y and Z never have an enable set in the same cycle, and X is never enabled together with Y or Z.
- R10: Lane b covers data bits [8b+7:8b]. Bit 1 of each enable vector is the upper byte (15:8) and bit 0 is the lower byte (7:0). Lanes are enabled independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_even | input | 1 | 1 selects the Y bank, 0 selects the Z bank |
| xmit | input | 1 | 1: X is the source and the memory port drives; 0: X drives |
| lane_oe_n | input | 2 | Active-low byte-lane enables, bit 1 upper |
| ld_xy | input | 1 | Load enable of the Y write register |
| ld_xz | input | 1 | Load enable of the Z write register |
| ld_yx | input | 1 | Load enable of the Y read register |
| ld_zx | input | 1 | Load enable of the Z read register |
| x_in | input | 16 | X port input bus |
| x_out | output | 16 | X port output bus |
| x_oe | output | 2 | X per-lane output enables |
| y_in | input | 16 | Y port input bus |
| y_out | output | 16 | Y port output bus |
| y_oe | output | 2 | Y per-lane output enables |
| z_in | input | 16 | Z port input bus |
| z_out | output | 16 | Z port output bus |
| z_oe | output | 2 | Z per-lane output enables |

## Verification
The bench builds the block with its default parameters: two 8-bit lanes. At that size all 16 combinations of bank select, direction and the two lane enables fit in one table, and each is checked against the decode in every mode, including both single-lane cases. Two lanes are also the smallest width at which a lane mix-up shows, because an upper-only pattern must not enable the lower lane. Directed steps load each of the four hold registers with distinct values. They then change the source buses with the load enables low and confirm that the outputs keep the loaded values.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE = 3'd0,
        MODE_RD_Y = 3'd1,
        MODE_WR_Y = 3'd2,
        MODE_RD_Z = 3'd3,
        MODE_WR_Z = 3'd4
    } xfer_mode_e;
endpackage

// File: rtl/xchg_hold_reg.sv
module xchg_hold_reg #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int W     = LANE_W * LANES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[b*LANE_W +: LANE_W] <= '0;
            else if (ld)
                q[b*LANE_W +: LANE_W] <= d[b*LANE_W +: LANE_W];
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
endmodule

// File: rtl/xchg_oe_decode.sv
module xchg_oe_decode
    import xchg_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             rst_n,
    input  logic             bank_even,
    input  logic             xmit,
    input  logic [LANES-1:0] lane_oe_n,
    output xfer_mode_e       mode,
    output logic [LANES-1:0] x_oe,
    output logic [LANES-1:0] y_oe,
    output logic [LANES-1:0] z_oe
);
    logic [LANES-1:0] lane_on;
    assign lane_on = ~lane_oe_n;

    always_comb begin
        if (!rst_n || (lane_on == '0))
            mode = MODE_IDLE;
        else if (bank_even)
            mode = xmit ? MODE_WR_Y : MODE_RD_Y;
        else
            mode = xmit ? MODE_WR_Z : MODE_RD_Z;
    end

    always_comb begin
        x_oe = '0;
        y_oe = '0;
        z_oe = '0;
        unique case (mode)
            MODE_IDLE: ;
            MODE_RD_Y,
            MODE_RD_Z: x_oe = lane_on;
            MODE_WR_Y: y_oe = lane_on;
            MODE_WR_Z: z_oe = lane_on;
            default:   ;
        endcase
    end
endmodule

// File: rtl/xchg_read_mux.sv
module xchg_read_mux #(
    parameter int W = 16
) (
    input  logic         sel_y,
    input  logic [W-1:0] from_y,
    input  logic [W-1:0] from_z,
    output logic [W-1:0] dout
);
    always_comb dout = sel_y ? from_y : from_z;
endmodule

// File: rtl/tri_port_xchg.sv
module tri_port_xchg
    import xchg_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_even,
    input  logic             xmit,
    input  logic [LANES-1:0] lane_oe_n,
    input  logic             ld_xy,
    input  logic             ld_xz,
    input  logic             ld_yx,
    input  logic             ld_zx,
    input  logic [W-1:0]     x_in,
    output logic [W-1:0]     x_out,
    output logic [LANES-1:0] x_oe,
    input  logic [W-1:0]     y_in,
    output logic [W-1:0]     y_out,
    output logic [LANES-1:0] y_oe,
    input  logic [W-1:0]     z_in,
    output logic [W-1:0]     z_out,
    output logic [LANES-1:0] z_oe
);
    xfer_mode_e mode;
    logic [W-1:0] rd_y, rd_z;

    xchg_hold_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_wr_y (
        .clk(clk), .rst_n(rst_n), .ld(ld_xy), .d(x_in), .q(y_out));
    xchg_hold_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_wr_z (
        .clk(clk), .rst_n(rst_n), .ld(ld_xz), .d(x_in), .q(z_out));
    xchg_hold_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_rd_y (
        .clk(clk), .rst_n(rst_n), .ld(ld_yx), .d(y_in), .q(rd_y));
    xchg_hold_reg #(.LANE_W(LANE_W), .LANES(LANES)) u_rd_z (
        .clk(clk), .rst_n(rst_n), .ld(ld_zx), .d(z_in), .q(rd_z));

    xchg_read_mux #(.W(W)) u_mux (
        .sel_y(bank_even), .from_y(rd_y), .from_z(rd_z), .dout(x_out));

    xchg_oe_decode #(.LANES(LANES)) u_dec (
        .rst_n(rst_n), .bank_even(bank_even), .xmit(xmit),
        .lane_oe_n(lane_oe_n), .mode(mode),
        .x_oe(x_oe), .y_oe(y_oe), .z_oe(z_oe));

    always_comb begin
        if (!rst_n)
            assert_reset_quiet_R1: assert ((x_oe | y_oe | z_oe) == '0);
    end

    assert_idle_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&lane_oe_n) |-> ((x_oe | y_oe | z_oe) == '0));
    assert_bank_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !((|y_oe) && (|z_oe)));
    assert_x_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|x_oe) |-> ((y_oe | z_oe) == '0));
    assert_rd_y_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_yx && bank_even) |=> (!bank_even || x_out == $past(y_in)));
endmodule

// File: tb/tri_port_xchg_tb.sv
module tri_port_xchg_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bank_even = 1'b0, xmit = 1'b0;
    logic [1:0] lane_oe_n = 2'b11;
    logic ld_xy = 0, ld_xz = 0, ld_yx = 0, ld_zx = 0;
    logic [15:0] x_in = '0, y_in = '0, z_in = '0;
    logic [15:0] x_out, y_out, z_out;
    logic [1:0] x_oe, y_oe, z_oe;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    tri_port_xchg u_dut (
        .clk(clk), .rst_n(rst_n), .bank_even(bank_even), .xmit(xmit),
        .lane_oe_n(lane_oe_n), .ld_xy(ld_xy), .ld_xz(ld_xz), .ld_yx(ld_yx),
        .ld_zx(ld_zx), .x_in(x_in), .x_out(x_out), .x_oe(x_oe),
        .y_in(y_in), .y_out(y_out), .y_oe(y_oe), .z_in(z_in),
        .z_out(z_out), .z_oe(z_oe));

    // {bank_even, xmit, lane_oe_n[1:0], x_oe, y_oe, z_oe}
    localparam logic [9:0] VEC [16] = '{
        10'b0_0_00_11_00_00, 10'b0_0_01_10_00_00, 10'b0_0_10_01_00_00, 10'b0_0_11_00_00_00,
        10'b0_1_00_00_00_11, 10'b0_1_01_00_00_10, 10'b0_1_10_00_00_01, 10'b0_1_11_00_00_00,
        10'b1_0_00_11_00_00, 10'b1_0_01_10_00_00, 10'b1_0_10_01_00_00, 10'b1_0_11_00_00_00,
        10'b1_1_00_00_11_00, 10'b1_1_01_00_10_00, 10'b1_1_10_00_01_00, 10'b1_1_11_00_00_00
    };

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with controls asking for transfers
        lane_oe_n = 2'b00; xmit = 1'b1; bank_even = 1'b1;
        ld_xy = 1; x_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        check16("R1 y_out", y_out, 16'h0);
        check16("R1 oe", {10'b0, x_oe, y_oe, z_oe}, 16'h0);
        xmit = 1'b0; #1;
        check16("R1 x_oe", {14'b0, x_oe}, 16'h0);
        ld_xy = 0;
        rst_n = 1'b1;
        tick;

        // R6 R7 R8 R9 R10: full decode table
        for (int i = 0; i < 16; i++) begin
            {bank_even, xmit, lane_oe_n} = VEC[i][9:6];
            #1;
            check16("R6 R7 R8 R9 R10 decode", {10'b0, x_oe, y_oe, z_oe}, {10'b0, VEC[i][5:0]});
        end
        lane_oe_n = 2'b11;

        // R2: write registers
        x_in = 16'hA5C3; ld_xy = 1; tick; ld_xy = 0;
        check16("R2 y_out", y_out, 16'hA5C3);
        x_in = 16'h5E17; ld_xz = 1; tick; ld_xz = 0;
        check16("R2 z_out", z_out, 16'h5E17);
        check16("R3 y_out kept when ld_xy low", y_out, 16'hA5C3);
        x_in = 16'h0000; tick; tick;
        check16("R3 y_out hold", y_out, 16'hA5C3);
        check16("R3 z_out hold", z_out, 16'h5E17);

        // R4 R5: read registers and bank mux
        y_in = 16'h1234; z_in = 16'hABCD; ld_yx = 1; ld_zx = 1; tick;
        ld_yx = 0; ld_zx = 0;
        bank_even = 1'b1; #1;
        check16("R4 R5 x_out from Y", x_out, 16'h1234);
        bank_even = 1'b0; #1;
        check16("R4 R5 x_out from Z", x_out, 16'hABCD);
        y_in = 16'hDEAD; z_in = 16'hBEEF; tick; tick;
        check16("R3 z read hold", x_out, 16'hABCD);
        bank_even = 1'b1; #1;
        check16("R3 y read hold", x_out, 16'h1234);

        // R4: only one read register loads
        z_in = 16'h7777; ld_zx = 1; tick; ld_zx = 0;
        check16("R4 Y kept while Z loads", x_out, 16'h1234);
        bank_even = 1'b0; #1;
        check16("R4 Z loaded", x_out, 16'h7777);

        // R1: reset clears loaded contents
        rst_n = 1'b0; #1;
        check16("R1 reset clears y_out", y_out, 16'h0);
        check16("R1 reset clears x_out", x_out, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule